// File: doc/BRIEF.md
# Processor Condition and Interrupt Register

This block keeps the processor's condition flags, the interrupt enables of the flags that can be masked, and a 3-bit priority-interrupt channel number. Other parts of the machine report conditions on a vector of event inputs, one bit per flag. An event sets its flag, and the flag stays set until software clears it. Software reaches the block through one 36-bit control word and one 36-bit status word. Bit positions below count from the most significant end: position p is vector index 35-p, so positions 33 to 35 are indices 2 down to 0, and position 35 is the least significant channel bit.

In one control write, separate positions set an enable, clear an enable, clear a flag, load the channel and request an I/O bus reset. Software cannot set a flag. The positions in the control word do not match the positions in the status word. The block raises one request line for the assigned channel whenever a condition is pending. A condition is pending when one of the four unmasked flags is set, or when a maskable flag is set and its enable is on.

The bus reset output comes from a two-state controller. In CTL_IDLE the output is low. A control write with position 19 set (the "bus reset write" transition) moves it to CTL_BUSRST, where the output is high. It leaves CTL_BUSRST for CTL_IDLE on the first cycle without such a write ("pulse done"). If such writes come back to back, it stays in CTL_BUSRST.

Top module: `cond_irq_reg`

## Requirements
- R1: While rst_n is low, and after it is released, every flag, enable and the channel are 0. rd_data reads 0 when io_user_i and trap_ofs_i are 0, irq_o is 0 and bus_rst_o is 0.
- R2: The ev_i bits map to flags as follows: bit 0 pushdown overflow, bit 1 protected-region write, bit 2 memory protect, bit 3 nonexistent memory, bit 4 clock, bit 5 floating overflow, bit 6 arithmetic overflow. A 1 on an event bit sets its flag from the next cycle. The flag then holds until it is cleared.
- R3: A control write clears flags at these positions: 18 pushdown overflow, 20 protected-region write, 22 memory protect, 23 nonexistent memory, 26 clock, 29 floating overflow, 32 arithmetic overflow. The flag reads 0 from the next cycle. If the flag's event arrives in the same cycle as the clear, the flag stays 1.
- R4: Control positions 24 and 25 clear and set the clock enable. Positions 27 and 28 clear and set the floating-overflow enable. Positions 30 and 31 clear and set the arithmetic-overflow enable. If the set and the clear for one enable are both 1, the enable becomes 1.
- R5: Every control write loads the channel from positions 33 to 35, with position 35 as the least significant bit.
- R6: A control write with position 19 set drives bus_rst_o high for the next cycle only, unless the next cycle's write also has position 19 set. The same write sets all enables and the channel to 0, which overrides any enable set and channel value in that word. Flags are not affected.
- R7: The status word reads as follows: 18 protected-region write; 19 pushdown overflow; 20 io_user_i; 22 memory protect; 23 nonexistent memory; 25 clock enable; 26 clock flag; 28 floating-overflow enable; 29 floating-overflow flag; 30 trap_ofs_i; 31 arithmetic-overflow enable; 32 arithmetic-overflow flag; 33 to 35 the channel.
- R8: Status positions 0 to 17, 21, 24 and 27 always read 0.
- R9: The clock, floating-overflow and arithmetic-overflow flags are pending only while their enable is 1.
- R10: The pushdown-overflow, protected-region-write, memory-protect and nonexistent-memory flags are pending whenever they are set, whatever the enables.
- R11: irq_o[c] is 1 exactly when a condition is pending and the channel equals c. With channel 0, irq_o is all zero. At most one bit of irq_o is 1.
- R12: A cycle with wr_en low and no events leaves the flags, enables and channel unchanged, whatever is on wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 36 | Control word |
| ev_i | input | 7 | Condition events, one per flag |
| io_user_i | input | 1 | I/O user-mode state, shown in the status word |
| trap_ofs_i | input | 1 | Trap-offset mode state, shown in the status word |
| rd_data | output | 36 | Status word |
| irq_o | output | 7 | Interrupt request per channel, indices 7 down to 1 |
| bus_rst_o | output | 1 | I/O bus reset pulse |

## Verification
The bench builds the block with its defaults: a 36-bit word, a 3-bit channel field and therefore seven request lines. With these values every channel value and every combination of flags and enables can be reached in a few thousand random cycles. Directed sequences cover the orderings that random stimulus seldom hits: a clear in the same cycle as an event, set and clear of one enable in the same word, a bus reset write that also sets an enable and loads a channel, and a write that loads channel 0 while a flag is pending.

// File: rtl/cir_pkg.sv
package cir_pkg;
    parameter int WORD_W     = 36;
    parameter int CH_W       = 3;
    parameter int NUM_FLAGS  = 7;
    parameter int NUM_UNCOND = 4;
    localparam int NUM_EN    = NUM_FLAGS - NUM_UNCOND;
    localparam int NUM_CH    = 1 << CH_W;

    localparam int POS_BUSRST = 19;
    localparam int POS_IOUSER = 20;
    localparam int POS_TRAPOF = 30;

    typedef enum logic [0:0] {CTL_IDLE, CTL_BUSRST} ctl_state_e;

    function automatic int pos_idx(input int pos, input int w);
        return w - 1 - pos;
    endfunction

    function automatic int flag_clr_pos(input int f);
        case (f)
            0: return 18;
            1: return 20;
            2: return 22;
            3: return 23;
            4: return 26;
            5: return 29;
            default: return 32;
        endcase
    endfunction

    function automatic int flag_rd_pos(input int f);
        case (f)
            0: return 19;
            1: return 18;
            2: return 22;
            3: return 23;
            4: return 26;
            5: return 29;
            default: return 32;
        endcase
    endfunction

    function automatic int en_clr_pos(input int e);
        return 24 + 3 * e;
    endfunction

    function automatic int en_set_pos(input int e);
        return 25 + 3 * e;
    endfunction
endpackage

// File: rtl/cir_flags.sv
module cir_flags
    import cir_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NF = NUM_FLAGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [NF-1:0] ev_i,
    output logic [NF-1:0] flag_q
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        localparam int CI = pos_idx(flag_clr_pos(i), W);
        logic clr;
        assign clr = wr_en && wr_data[CI];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (ev_i[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr) begin
                flag_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cir_ctrl.sv
module cir_ctrl
    import cir_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int CW  = CH_W,
    parameter int NE  = NUM_EN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [NE-1:0] en_q,
    output logic [CW-1:0] chan_q,
    output logic          bus_rst_o
);
    localparam int BR_IDX = pos_idx(POS_BUSRST, W);

    ctl_state_e state_q, state_d;
    logic       rst_req;

    assign rst_req = wr_en && wr_data[BR_IDX];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE:   if (rst_req)  state_d = CTL_BUSRST;
            CTL_BUSRST: if (!rst_req) state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_rst_o = (state_q == CTL_BUSRST);
    end

    for (genvar e = 0; e < NE; e++) begin : g_en
        localparam int SI = pos_idx(en_set_pos(e), W);
        localparam int CI = pos_idx(en_clr_pos(e), W);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[e] <= 1'b0;
            end else if (rst_req) begin
                en_q[e] <= 1'b0;
            end else if (wr_en && wr_data[SI]) begin
                en_q[e] <= 1'b1;
            end else if (wr_en && wr_data[CI]) begin
                en_q[e] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else if (wr_en) begin
            chan_q <= rst_req ? '0 : wr_data[CW-1:0];
        end
    end
endmodule

// File: rtl/cir_irq.sv
module cir_irq
    import cir_pkg::*;
#(
    parameter int NF  = NUM_FLAGS,
    parameter int NU  = NUM_UNCOND,
    parameter int CW  = CH_W,
    localparam int NE = NF - NU,
    localparam int NC = 1 << CW
) (
    input  logic [NF-1:0] flag_q,
    input  logic [NE-1:0] en_q,
    input  logic [CW-1:0] chan_q,
    output logic [NC-1:1] irq_o
);
    logic pending;

    assign pending = (|flag_q[NU-1:0]) || (|(flag_q[NF-1:NU] & en_q));

    for (genvar c = 1; c < NC; c++) begin : g_ch
        assign irq_o[c] = pending && (chan_q == CW'(c));
    end
endmodule

// File: rtl/cond_irq_reg.sv
module cond_irq_reg
    import cir_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int CW  = CH_W,
    parameter int NF  = NUM_FLAGS,
    localparam int NE = NF - NUM_UNCOND,
    localparam int NC = 1 << CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [NF-1:0] ev_i,
    input  logic          io_user_i,
    input  logic          trap_ofs_i,
    output logic [W-1:0]  rd_data,
    output logic [NC-1:1] irq_o,
    output logic          bus_rst_o
);
    logic [NF-1:0] flag_q;
    logic [NE-1:0] en_q;
    logic [CW-1:0] chan_q;

    cir_flags #(.W(W), .NF(NF)) u_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ev_i(ev_i), .flag_q(flag_q)
    );

    cir_ctrl #(.W(W), .CW(CW), .NE(NE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .en_q(en_q), .chan_q(chan_q), .bus_rst_o(bus_rst_o)
    );

    cir_irq #(.NF(NF), .NU(NUM_UNCOND), .CW(CW)) u_irq (
        .flag_q(flag_q), .en_q(en_q), .chan_q(chan_q), .irq_o(irq_o)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NF; i++) begin
            rd_data[pos_idx(flag_rd_pos(i), W)] = flag_q[i];
        end
        for (int e = 0; e < NE; e++) begin
            rd_data[pos_idx(en_set_pos(e), W)] = en_q[e];
        end
        rd_data[pos_idx(POS_IOUSER, W)] = io_user_i;
        rd_data[pos_idx(POS_TRAPOF, W)] = trap_ofs_i;
        rd_data[CW-1:0] = chan_q;
    end
endmodule

// File: rtl/cir_chk.sv
module cir_chk
    import cir_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [WORD_W-1:0]    wr_data,
    input logic [NUM_FLAGS-1:0] ev_i,
    input logic [WORD_W-1:0]    rd_data,
    input logic [NUM_CH-1:1]    irq_o,
    input logic                 bus_rst_o
);
    localparam logic [WORD_W-1:0] STATE_MASK =
        ~((WORD_W'(1) << 15) | (WORD_W'(1) << 5));

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i[0] |=> rd_data[16]);

    assert_clear_loses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[9] && ev_i[4]) |=> rd_data[9]);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[10] && wr_data[11] && !wr_data[16]) |=> rd_data[10]);

    assert_busrst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[16]) |=> (bus_rst_o && rd_data[2:0] == 3'd0 && !rd_data[10]));

    assert_no_spurious_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[16]) |=> !bus_rst_o);

    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[35:18] == '0 && !rd_data[14] && !rd_data[11] && !rd_data[8]));

    assert_uncond_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[16] && rd_data[2:0] != 3'd0) |-> (irq_o != '0));

    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    assert_ch0_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2:0] == 3'd0) |-> (irq_o == '0));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && ev_i == '0) |=> $stable(rd_data & STATE_MASK));
endmodule

bind cond_irq_reg cir_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ev_i(ev_i),
    .rd_data(rd_data), .irq_o(irq_o), .bus_rst_o(bus_rst_o)
);

// File: tb/sim_cond_irq_reg.sv
module sim_cond_irq_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic [6:0]  ev_i = '0;
    logic        io_user_i = 1'b0;
    logic        trap_ofs_i = 1'b0;
    logic [35:0] rd_data;
    logic [7:1]  irq_o;
    logic        bus_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    cond_irq_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ev_i(ev_i),
        .io_user_i(io_user_i), .trap_ofs_i(trap_ofs_i),
        .rd_data(rd_data), .irq_o(irq_o), .bus_rst_o(bus_rst_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int ix(input int pos);
        return 35 - pos;
    endfunction

    // reference model state
    bit m_flag[7];
    bit m_en[3];
    int m_ch = 0;
    bit m_brst = 0;
    int clr_pos[7] = '{18, 20, 22, 23, 26, 29, 32};
    int rdp[7]     = '{19, 18, 22, 23, 26, 29, 32};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] model_rd();
        logic [35:0] r = '0;
        for (int i = 0; i < 7; i++) r[ix(rdp[i])] = m_flag[i];
        for (int e = 0; e < 3; e++) r[ix(25 + 3 * e)] = m_en[e];
        r[ix(20)] = io_user_i;
        r[ix(30)] = trap_ofs_i;
        r[2:0] = 3'(m_ch);
        return r;
    endfunction

    function automatic logic [6:0] model_irq();
        bit pend = 0;
        logic [6:0] r = '0;
        for (int i = 0; i < 4; i++) if (m_flag[i]) pend = 1;
        for (int e = 0; e < 3; e++) if (m_flag[4 + e] && m_en[e]) pend = 1;
        if (pend && m_ch != 0) r[m_ch - 1] = 1'b1;
        return r;
    endfunction

    always begin
        @(posedge clk);
        if (!rst_n) begin
            foreach (m_flag[i]) m_flag[i] = 0;
            foreach (m_en[e]) m_en[e] = 0;
            m_ch = 0;
            m_brst = 0;
        end else begin
            m_brst = wr_en && wr_data[ix(19)];
            for (int i = 0; i < 7; i++) begin
                if (wr_en && wr_data[ix(clr_pos[i])]) m_flag[i] = 0;
                if (ev_i[i]) m_flag[i] = 1;
            end
            if (wr_en) begin
                for (int e = 0; e < 3; e++) begin
                    if (wr_data[ix(24 + 3 * e)]) m_en[e] = 0;
                    if (wr_data[ix(25 + 3 * e)]) m_en[e] = 1;
                    if (m_brst) m_en[e] = 0;
                end
                m_ch = m_brst ? 0 : int'(wr_data[2:0]);
            end
        end
        #2;
        if (!done) begin
            chk("R7 status word", 64'(rd_data), 64'(model_rd()));
            chk("R11 request lines", 64'(irq_o), 64'(model_irq()));
            chk("R6 bus reset pulse", 64'(bus_rst_o), 64'(m_brst));
        end
    end

    task automatic cyc(input logic w, input logic [35:0] d, input logic [6:0] e);
        @(negedge clk);
        wr_en = w;
        wr_data = d;
        ev_i = e;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [35:0] b(input int pos);
        return 36'(1) << (35 - pos);
    endfunction

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 status in reset", 64'(rd_data), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, '0, '0);
        chk("R1 status after reset", 64'(rd_data), 64'h0);
        chk("R1 requests after reset", 64'(irq_o), 64'h0);
        chk("R1 bus reset idle", 64'(bus_rst_o), 64'h0);

        cyc(0, '0, 7'h10);
        chk("R2 clock flag set", 64'(rd_data), 64'h200);
        cyc(0, '0, '0);
        chk("R2 clock flag held", 64'(rd_data), 64'h200);

        cyc(1, b(25) | 36'd3, '0);
        chk("R5 channel 3 loaded", 64'(rd_data), 64'h603);
        chk("R9 enabled clock flag requests", 64'(irq_o), 64'h04);

        cyc(1, b(26) | b(25) | 36'd3, 7'h10);
        chk("R3 clear loses to event", 64'(rd_data), 64'h603);
        cyc(1, b(26) | 36'd3, '0);
        chk("R3 clock flag cleared", 64'(rd_data), 64'h403);
        chk("R9 no request without flag", 64'(irq_o), 64'h0);

        cyc(1, b(24) | 36'd3, '0);
        chk("R4 clock enable cleared", 64'(rd_data), 64'h003);
        cyc(1, b(24) | b(25) | 36'd3, '0);
        chk("R4 set wins over clear", 64'(rd_data), 64'h403);

        cyc(1, 36'd0, '0);
        cyc(0, '0, 7'h08);
        chk("R11 channel 0 no request", 64'(irq_o), 64'h0);
        chk("R2 nonexistent-memory flag", 64'(rd_data), 64'h1400);
        cyc(1, b(25) | 36'd7, '0);
        chk("R10 unconditional request on 7", 64'(irq_o), 64'h40);

        cyc(1, b(19) | b(28) | 36'd5, '0);
        chk("R6 enables and channel reset", 64'(rd_data), 64'h1000);
        chk("R6 pulse high", 64'(bus_rst_o), 64'h1);
        cyc(0, '0, '0);
        chk("R6 pulse ends", 64'(bus_rst_o), 64'h0);

        cyc(0, {36{1'b1}}, '0);
        chk("R12 write strobe low ignored", 64'(rd_data), 64'h1000);

        cyc(0, '0, 7'h7f);
        cyc(1, b(25) | b(28) | b(31) | 36'd6, '0);
        chk("R8 unused positions zero", 64'(rd_data & ~(b(18) | b(19) | b(20) | b(22) |
            b(23) | b(25) | b(26) | b(28) | b(29) | b(30) | b(31) | b(32) | 36'h7)), 64'h0);
        chk("R10 request on channel 6", 64'(irq_o), 64'h20);

        @(negedge clk);
        io_user_i = 1'b1;
        trap_ofs_i = 1'b1;
        cyc(0, '0, '0);
        chk("R7 mode inputs shown", 64'(rd_data[15]), 64'h1);
        chk("R7 trap offset shown", 64'(rd_data[5]), 64'h1);

        for (int n = 0; n < 3000; n++) begin
            logic [35:0] d;
            logic [6:0] e;
            d = {$urandom, $urandom} & 36'h3_FFFF;
            if (($urandom % 8) != 0) d[16] = 1'b0;
            e = 7'($urandom) & 7'($urandom) & 7'($urandom);
            @(negedge clk);
            io_user_i = 1'($urandom);
            trap_ofs_i = 1'($urandom);
            wr_en = (($urandom % 3) == 0);
            wr_data = d;
            ev_i = e;
        end
        cyc(0, '0, '0);
        finish_run();
    end
endmodule